// File: doc/BRIEF.md
# Colour Marker Centroid Locator

The block finds the centre of four coloured markers placed at the corners of a target in a video frame. The capture path upstream classifies each pixel and passes on only those that match one of four marker colours. Each of these pixels arrives with a two-bit colour tag and its x and y position. For every colour the block keeps a running x total, a running y total and a pixel count while the frame streams in.

An end-of-frame strobe freezes the totals. The block then divides each total by its colour's count, which gives the mean position of that marker. The result is four corner points, and a one-cycle result-valid pulse marks the moment all of them are final. One restoring divider is shared by all eight divisions, and they run one after another. The running totals restart from zero right after the strobe, so pixels of the next frame can arrive while the divisions are still in progress.

Top module: `marker_centroid`

## Requirements
- R1: After reset every corner coordinate is 0, every missing flag is 0 and resultValid is 0.
- R2: A pixel is counted only when pixValid is 1. With pixValid at 0 the tag and coordinates have no effect on any later result.
- R3: Tag value t (0 to 3) adds the pixel's x and y to the totals of corner t, and the averages appear on cornerX[t] and cornerY[t].
- R4: When a frame closes, each corner with at least one hit reports floor(sum of x / hits) and floor(sum of y / hits) over that frame's pixels with that tag.
- R5: A valid pixel presented in the same cycle as frameEnd belongs to the frame that is closing. Every frame's totals start from zero.
- R6: A corner with zero hits in a frame keeps its previous coordinates and raises cornerMissing[t]. A corner with hits clears cornerMissing[t].
- R7: resultValid is a one-cycle pulse. It rises exactly 8*(SUM_W+2) clock cycles after the cycle in which frameEnd is sampled, and all corner outputs are final while it is high.
- R8: A frameEnd that arrives while divisions are still running abandons them and restarts the sequence on the new frame's totals. No pulse is issued for the abandoned frame.
- R9: At most one divider operation (load, step or store) happens per cycle, and a frame close suppresses all three in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pixValid | input | 1 | Tagged pixel present this cycle |
| pixTag | input | 2 | Marker colour index of the pixel |
| pixX | input | X_W | Pixel column |
| pixY | input | Y_W | Pixel row |
| frameEnd | input | 1 | Closes the current frame |
| cornerX | output | 4*X_W | Mean column per corner, packed [3:0][X_W-1:0] |
| cornerY | output | 4*Y_W | Mean row per corner, packed [3:0][Y_W-1:0] |
| cornerMissing | output | 4 | Corner had no hits in the last frame |
| resultValid | output | 1 | All four corners updated (one-cycle pulse) |

## Verification
Suppose an accumulator misses a clear, or a pixel on the frameEnd cycle is dropped. The corner coordinate then comes out wrong at the very next resultValid pulse. Suppose instead the divider control loses its place. The pulse then arrives at the wrong cycle count, or lands on the wrong corner or axis. That shows at once as a latency mismatch or as swapped coordinates. A missing-flag fault shows up as a corner that moves when it should hold. Frames that leave out one colour are followed by full frames to bring this out.

// File: rtl/centroid_pkg.sv
package centroid_pkg;
  localparam int NCOL  = 4;
  localparam int TAG_W = 2;
  localparam int NDIV  = 2 * NCOL;
  localparam int IDX_W = $clog2(NDIV);

  typedef struct packed {
    logic             snap;      // freeze totals, clear accumulators
    logic             loadDiv;   // load dividend/divisor for divIdx
    logic             stepDiv;   // one restoring step
    logic             storeRes;  // write quotient to its corner
    logic             lastDone;  // final division of the sequence
    logic [IDX_W-1:0] divIdx;    // {colour, axis}
  } ctrlStrobes_t;
endpackage

// File: rtl/centroid_ctrl.sv
module centroid_ctrl
  import centroid_pkg::*;
#(
  parameter int SUM_W = 28
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         frameEnd,
  output ctrlStrobes_t st
);
  localparam int STEP_W = $clog2(SUM_W + 1);

  typedef enum logic [1:0] {IDLE, LOAD, STEP, STORE} ctrlState_t;

  ctrlState_t       state;
  logic [STEP_W-1:0] stepCnt;
  logic [IDX_W-1:0] idx;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= IDLE;
      stepCnt <= '0;
      idx     <= '0;
    end else if (frameEnd) begin
      state   <= LOAD;
      stepCnt <= '0;
      idx     <= '0;
    end else begin
      case (state)
        LOAD: begin
          state   <= STEP;
          stepCnt <= '0;
        end
        STEP: begin
          if (stepCnt == STEP_W'(SUM_W - 1)) state <= STORE;
          stepCnt <= stepCnt + 1'b1;
        end
        STORE: begin
          if (idx == IDX_W'(NDIV - 1)) begin
            state <= IDLE;
          end else begin
            state <= LOAD;
            idx   <= idx + 1'b1;
          end
        end
        default: state <= IDLE;
      endcase
    end
  end

  always_comb begin
    st          = '0;
    st.snap     = frameEnd;
    st.divIdx   = idx;
    st.loadDiv  = !frameEnd && (state == LOAD);
    st.stepDiv  = !frameEnd && (state == STEP);
    st.storeRes = !frameEnd && (state == STORE);
    st.lastDone = !frameEnd && (state == STORE) && (idx == IDX_W'(NDIV - 1));
  end

  // R9: divider operations never overlap
  p_one_op_r9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({st.snap, st.loadDiv, st.stepDiv, st.storeRes}));

  // R8: a frame close always restarts at the first division
  p_restart_r8: assert property (@(posedge clk) disable iff (!rstN)
    frameEnd |=> (state == LOAD) && (idx == '0));

  // R7: step counter stays within the dividend width
  p_step_range_r7: assert property (@(posedge clk) disable iff (!rstN)
    (state == STEP) |-> (stepCnt < STEP_W'(SUM_W)));
endmodule

// File: rtl/centroid_datapath.sv
module centroid_datapath
  import centroid_pkg::*;
#(
  parameter int X_W   = 10,
  parameter int Y_W   = 9,
  parameter int SUM_W = 28,
  parameter int CNT_W = 19
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      pixValid,
  input  logic [TAG_W-1:0]          pixTag,
  input  logic [X_W-1:0]            pixX,
  input  logic [Y_W-1:0]            pixY,
  input  ctrlStrobes_t              st,
  output logic [NCOL-1:0][X_W-1:0]  cornerX,
  output logic [NCOL-1:0][Y_W-1:0]  cornerY,
  output logic [NCOL-1:0]           cornerMissing,
  output logic                      resultValid
);
  logic [NCOL-1:0]            hitVec;
  logic [NCOL-1:0][SUM_W-1:0] accX, accY, snapX, snapY;
  logic [NCOL-1:0][CNT_W-1:0] accCnt, snapCnt;

  logic [SUM_W-1:0] divQ;
  logic [CNT_W-1:0] divRem, divDen;
  logic [CNT_W:0]   trial;
  logic             trialOk;
  logic [TAG_W-1:0] selCol;
  logic             selAxisY;

  assign selCol   = st.divIdx[IDX_W-1:1];
  assign selAxisY = st.divIdx[0];

  for (genvar c = 0; c < NCOL; c++) begin : g_hit
    assign hitVec[c] = pixValid && (pixTag == TAG_W'(c));
  end

  // Per-colour running totals and frame snapshot
  always_ff @(posedge clk) begin
    if (!rstN) begin
      accX <= '0; accY <= '0; accCnt <= '0;
      snapX <= '0; snapY <= '0; snapCnt <= '0;
    end else begin
      for (int c = 0; c < NCOL; c++) begin
        if (st.snap) begin
          snapX[c]   <= accX[c] + (hitVec[c] ? SUM_W'(pixX) : '0);
          snapY[c]   <= accY[c] + (hitVec[c] ? SUM_W'(pixY) : '0);
          snapCnt[c] <= accCnt[c] + CNT_W'(hitVec[c]);
          accX[c]    <= '0;
          accY[c]    <= '0;
          accCnt[c]  <= '0;
        end else if (hitVec[c]) begin
          accX[c]   <= accX[c] + SUM_W'(pixX);
          accY[c]   <= accY[c] + SUM_W'(pixY);
          accCnt[c] <= accCnt[c] + 1'b1;
        end
      end
    end
  end

  // Shared restoring divider: dividend register shifts into quotient
  assign trial   = {divRem, divQ[SUM_W-1]};
  assign trialOk = trial >= {1'b0, divDen};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divQ <= '0; divRem <= '0; divDen <= '0;
    end else if (st.loadDiv) begin
      divQ   <= selAxisY ? snapY[selCol] : snapX[selCol];
      divDen <= snapCnt[selCol];
      divRem <= '0;
    end else if (st.stepDiv) begin
      divRem <= trialOk ? CNT_W'(trial - {1'b0, divDen}) : trial[CNT_W-1:0];
      divQ   <= {divQ[SUM_W-2:0], trialOk};
    end
  end

  // Result registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cornerX <= '0; cornerY <= '0; cornerMissing <= '0; resultValid <= 1'b0;
    end else begin
      resultValid <= st.lastDone;
      if (st.storeRes) begin
        if (divDen == '0) begin
          cornerMissing[selCol] <= 1'b1;
        end else begin
          cornerMissing[selCol] <= 1'b0;
          if (selAxisY) cornerY[selCol] <= divQ[Y_W-1:0];
          else          cornerX[selCol] <= divQ[X_W-1:0];
        end
      end
    end
  end

  // R5: accumulators restart from zero after a frame close
  p_clear_r5: assert property (@(posedge clk) disable iff (!rstN)
    (st.snap && !pixValid) |=> (accCnt == '0) && (accX == '0) && (accY == '0));

  // R6: a corner without hits is not overwritten
  p_keep_missing_r6: assert property (@(posedge clk) disable iff (!rstN)
    (st.storeRes && (divDen == '0)) |=> $stable(cornerX) && $stable(cornerY) && (cornerMissing != '0));

  // R7: the pulse follows the last store only
  p_valid_after_last_r7: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |-> $past(st.storeRes));

  // R7: pulse lasts one cycle
  p_pulse_width_r7: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |=> !resultValid);
endmodule

// File: rtl/marker_centroid.sv
module marker_centroid
  import centroid_pkg::*;
#(
  parameter int X_W   = 10,
  parameter int Y_W   = 9,
  parameter int SUM_W = 28,
  parameter int CNT_W = 19
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     pixValid,
  input  logic [1:0]               pixTag,
  input  logic [X_W-1:0]           pixX,
  input  logic [Y_W-1:0]           pixY,
  input  logic                     frameEnd,
  output logic [3:0][X_W-1:0]      cornerX,
  output logic [3:0][Y_W-1:0]      cornerY,
  output logic [3:0]               cornerMissing,
  output logic                     resultValid
);
  ctrlStrobes_t st;

  centroid_ctrl #(.SUM_W(SUM_W)) uCtrl (
    .clk(clk), .rstN(rstN), .frameEnd(frameEnd), .st(st)
  );

  centroid_datapath #(.X_W(X_W), .Y_W(Y_W), .SUM_W(SUM_W), .CNT_W(CNT_W)) uData (
    .clk(clk), .rstN(rstN), .pixValid(pixValid), .pixTag(pixTag),
    .pixX(pixX), .pixY(pixY), .st(st),
    .cornerX(cornerX), .cornerY(cornerY),
    .cornerMissing(cornerMissing), .resultValid(resultValid)
  );
endmodule

// File: tb/marker_centroid_test.sv
module marker_centroid_test;
  localparam int X_W = 10, Y_W = 9, SUM_W = 28, CNT_W = 19;
  localparam int LAT = 8 * (SUM_W + 2);

  logic clk = 1'b0, rstN = 1'b0;
  logic pixValid = 1'b0, frameEnd = 1'b0;
  logic [1:0] pixTag = '0;
  logic [X_W-1:0] pixX = '0;
  logic [Y_W-1:0] pixY = '0;
  logic [3:0][X_W-1:0] cornerX;
  logic [3:0][Y_W-1:0] cornerY;
  logic [3:0] cornerMissing;
  logic resultValid;

  int checks = 0, errors = 0, cyc = 0;
  longint sx[4], sy[4], cn[4];
  int eX[4], eY[4];
  logic [3:0] eMiss;

  marker_centroid #(.X_W(X_W), .Y_W(Y_W), .SUM_W(SUM_W), .CNT_W(CNT_W)) uut (
    .clk(clk), .rstN(rstN), .pixValid(pixValid), .pixTag(pixTag),
    .pixX(pixX), .pixY(pixY), .frameEnd(frameEnd),
    .cornerX(cornerX), .cornerY(cornerY),
    .cornerMissing(cornerMissing), .resultValid(resultValid));

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic int avgOf(longint s, longint n);
    return int'(s / n);
  endfunction

  task automatic check(string req, longint act, longint exp);
    checks = checks + 1;
    if (act != exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clearModel();
    for (int c = 0; c < 4; c++) begin sx[c] = 0; sy[c] = 0; cn[c] = 0; end
  endtask

  task automatic closeModel();
    for (int c = 0; c < 4; c++) begin
      if (cn[c] == 0) eMiss[c] = 1'b1;
      else begin
        eMiss[c] = 1'b0;
        eX[c] = avgOf(sx[c], cn[c]);
        eY[c] = avgOf(sy[c], cn[c]);
      end
    end
    clearModel();
  endtask

  // one pixel cycle; inputs change mid-cycle away from the edge
  task automatic pix(bit v, int tag, int x, int y);
    @(negedge clk);
    pixValid = v; pixTag = 2'(tag); pixX = X_W'(x); pixY = Y_W'(y);
    @(posedge clk);
    if (v) begin sx[tag] += x; sy[tag] += y; cn[tag] += 1; end
    #1 pixValid = 1'b0;
  endtask

  task automatic closeFrame(bit v, int tag, int x, int y);
    @(negedge clk);
    frameEnd = 1'b1;
    pixValid = v; pixTag = 2'(tag); pixX = X_W'(x); pixY = Y_W'(y);
    @(posedge clk);
    if (v) begin sx[tag] += x; sy[tag] += y; cn[tag] += 1; end
    closeModel();
    #1 frameEnd = 1'b0; pixValid = 1'b0;
  endtask

  task automatic waitAndCheck(string tag);
    int n = 0;
    for (int i = 1; i <= LAT + 60; i++) begin
      @(posedge clk); #1;
      n = i;
      if (resultValid) break;
    end
    check({tag, " R7 latency"}, n, LAT);
    @(posedge clk); #1;
    check({tag, " R7 pulse width"}, resultValid, 0);
    for (int c = 0; c < 4; c++) begin
      check({tag, " R4 R3 cornerX"}, cornerX[c], eX[c]);
      check({tag, " R4 R3 cornerY"}, cornerY[c], eY[c]);
    end
    check({tag, " R6 missing"}, cornerMissing, eMiss);
  endtask

  task automatic randFrame(int n, logic [3:0] useMask);
    for (int i = 0; i < n; i++) begin
      int t = int'($urandom_range(0, 3));
      while (!useMask[t]) t = int'($urandom_range(0, 3));
      pix($urandom_range(0, 4) != 0, t, int'($urandom_range(0, 639)), int'($urandom_range(0, 479)));
    end
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    clearModel();
    for (int c = 0; c < 4; c++) begin eX[c] = 0; eY[c] = 0; end
    eMiss = '0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 resultValid", resultValid, 0);
    check("R1 missing", cornerMissing, 0);
    check("R1 cornerX", cornerX, 0);
    check("R1 cornerY", cornerY, 0);
    rstN = 1'b1;

    // directed: invalid pixels with large coords must not count (R2),
    // pixel on the close cycle counts (R5)
    pix(1, 0, 10, 20); pix(1, 0, 13, 25);
    pix(0, 0, 639, 479);
    pix(1, 1, 600, 30); pix(0, 1, 0, 0);
    pix(1, 2, 5, 470);
    pix(1, 3, 620, 460); pix(1, 3, 621, 461);
    closeFrame(1, 2, 7, 471);
    waitAndCheck("dir1 R2 R5");

    // random full frame, fresh totals (R5)
    randFrame(300, 4'b1111);
    closeFrame(1, 1, 100, 100);
    waitAndCheck("rand1");

    // colour 2 absent: holds value and flags missing (R6)
    randFrame(200, 4'b1011);
    closeFrame(0, 0, 0, 0);
    waitAndCheck("miss2 R6");

    // all colours back: flag clears
    randFrame(150, 4'b1111);
    pix(1, 2, 333, 222);
    closeFrame(0, 0, 0, 0);
    waitAndCheck("back R6");

    // restart while dividing (R8)
    randFrame(100, 4'b1111);
    closeFrame(0, 0, 0, 0);
    for (int i = 0; i < 4; i++) pix(1, i, 50 + i, 60 + i);
    for (int i = 0; i < 60; i++) begin
      pix(1, i % 4, int'($urandom_range(0, 639)), int'($urandom_range(0, 479)));
      check("R8 no early pulse", resultValid, 0);
    end
    closeFrame(0, 0, 0, 0);
    waitAndCheck("restart R8");

    // empty frame: every corner missing and held (R6)
    repeat (5) pix(0, 1, 400, 400);
    closeFrame(0, 0, 0, 0);
    waitAndCheck("empty R6");

    // single-pixel corners and mixed random frames
    pix(1, 0, 639, 479); pix(1, 1, 0, 0); pix(1, 2, 1, 1);
    closeFrame(1, 3, 320, 240);
    waitAndCheck("single R4");
    for (int f = 0; f < 4; f++) begin
      randFrame(int'($urandom_range(20, 400)), 4'($urandom_range(1, 15)));
      closeFrame($urandom_range(0, 1) == 1, int'($urandom_range(0, 3)), 9, 9);
      waitAndCheck("randmix");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule